// File: doc/BRIEF.md
# Four-Phase Parallel Byte Receiver

This block is the device end of a byte-wide parallel link that uses a four-phase, return-to-zero handshake. A host puts a byte on the data lines and raises a strobe. The receiver latches the byte on the first clock edge where it sees the strobe high, as long as it is ready for a new request. It then offers the byte on a valid/ready stream to a downstream consumer.

The receiver raises its acknowledge only after the consumer has taken the byte. It holds acknowledge until the host drops the strobe. It then lowers acknowledge and becomes ready again. A busy output tells the host whether a new request can be accepted. The block holds one byte only.

A strobe that is already high when the receiver starts waiting is not taken as a request. It counts only after the receiver has seen it low. This stops a stuck-high strobe after reset from latching a byte twice.

Top module: `pport_rx`

## Requirements
- R1: While reset is high, and in the first cycle after reset is released, `busy_o`, `ack_o` and `m_valid_o` are all 0.
- R2: `busy_o` is 0 while the receiver waits for a request. It is 1 from the cycle after a byte is latched until the cycle in which `ack_o` returns to 0.
- R3: When the receiver is waiting and armed, and `strb_i` is sampled high at a clock edge, `data_i` is latched at that edge. In the next cycle `m_valid_o` is 1 and `m_data_o` equals the latched byte.
- R4: While `m_valid_o` is 1 and `m_ready_i` is 0, `m_valid_o` stays 1 and `m_data_o` stays unchanged. Changes on `data_i` after the latch have no effect on `m_data_o`.
- R5: `ack_o` rises in the cycle after the edge where both `m_valid_o` and `m_ready_i` are 1. In that same cycle `m_valid_o` falls. `ack_o` never rises while a byte is still being offered.
- R6: `ack_o` stays 1 while `strb_i` is sampled high. In the cycle after `strb_i` is sampled low, `ack_o` and `busy_o` both fall and the receiver is armed for the next request.
- R7: A strobe that is high when the receiver enters its waiting state after reset latches nothing. A byte is latched only after `strb_i` has been sampled low at least once and then sampled high.
- R8: `m_ready_i` has no effect while no byte is being offered: `ack_o` and `m_valid_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strb_i | input | 1 | Host request strobe, high means data is presented |
| data_i | input | DATA_W | Host data lines |
| busy_o | output | 1 | High while a request cannot be accepted |
| ack_o | output | 1 | Acknowledge to the host |
| m_valid_o | output | 1 | Latched byte is offered downstream |
| m_data_o | output | DATA_W | Latched byte |
| m_ready_i | input | 1 | Downstream consumer takes the byte |

## Verification
A table of transfers is run in sequence. Each entry sets a byte value, a delay before the consumer is ready, and how long the host keeps the strobe up after acknowledge. A zero ready delay tells an immediate handoff apart from a stalled one. The data lines are inverted during stalls, which shows whether the offered byte really is held. Long strobe holds show whether acknowledge waits for the strobe to fall rather than dropping early. Directed cases cover:
- a strobe held high across reset, which separates correct arming from a double latch;
- a ready pulse with nothing held;
- back-to-back transfers with a single low strobe cycle between them.

// File: rtl/pprx_pkg.sv
package pprx_pkg;

    localparam int DEF_DATA_W = 8;

    // Link phase: waiting for a request, offering a byte, acknowledging
    typedef enum logic [1:0] {
        PH_WAIT  = 2'd0,
        PH_OFFER = 2'd1,
        PH_ACK   = 2'd2
    } phase_t;

    // Control outputs that follow from the phase
    typedef struct packed {
        logic busy;
        logic ack;
        logic offer;
    } link_ctl_t;

    function automatic link_ctl_t decode_phase(phase_t p);
        link_ctl_t c;
        c.busy  = (p != PH_WAIT);
        c.ack   = (p == PH_ACK);
        c.offer = (p == PH_OFFER);
        return c;
    endfunction

endpackage

// File: rtl/pprx_arm.sv
module pprx_arm (
    input  logic clk,
    input  logic rst,
    input  logic strb_i,
    input  logic in_wait_i,
    input  logic take_i,
    input  logic rearm_i,
    output logic go_o
);
    logic armed_q;

    // Armed only once the strobe has been seen low while waiting
    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (take_i)
            armed_q <= 1'b0;
        else if (rearm_i)
            armed_q <= 1'b1;
        else if (in_wait_i && !strb_i)
            armed_q <= 1'b1;
    end

    assign go_o = in_wait_i && armed_q && strb_i;

    // A request is never taken twice in a row
    AST_NO_DOUBLE_TAKE: assert property (@(posedge clk) disable iff (rst)
        take_i |=> !go_o); // R7

endmodule

// File: rtl/pprx_hold.sv
module pprx_hold #(
    parameter int DATA_W = pprx_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk) begin
        if (rst)
            byte_q <= '0;
        else if (load_i)
            byte_q <= data_i;
    end

    assign data_o = byte_q;

    // The held byte changes only on a load
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(byte_q)); // R4

endmodule

// File: rtl/pprx_fsm.sv
module pprx_fsm
    import pprx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      go_i,
    input  logic      ready_i,
    input  logic      strb_i,
    output logic      take_o,
    output logic      rearm_o,
    output link_ctl_t ctl_o
);
    phase_t phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        take_o  = 1'b0;
        rearm_o = 1'b0;
        case (phase_q)
            PH_WAIT: begin
                if (go_i) begin
                    phase_d = PH_OFFER;
                    take_o  = 1'b1;
                end
            end
            PH_OFFER: begin
                if (ready_i)
                    phase_d = PH_ACK;
            end
            PH_ACK: begin
                if (!strb_i) begin
                    phase_d = PH_WAIT;
                    rearm_o = 1'b1;
                end
            end
            default: phase_d = PH_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= PH_WAIT;
        else
            phase_q <= phase_d;
    end

    assign ctl_o = decode_phase(phase_q);

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.ack && strb_i) |=> ctl_o.ack); // R6
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.ack && !strb_i) |=> (!ctl_o.ack && !ctl_o.busy)); // R6
    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ctl_o.offer && !ready_i) |=> ctl_o.offer); // R4

endmodule

// File: rtl/pport_rx.sv
module pport_rx
    import pprx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strb_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              busy_o,
    output logic              ack_o,
    output logic              m_valid_o,
    output logic [DATA_W-1:0] m_data_o,
    input  logic              m_ready_i
);
    logic      go;
    logic      take;
    logic      rearm;
    link_ctl_t ctl;

    pprx_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .strb_i    (strb_i),
        .in_wait_i (!ctl.busy),
        .take_i    (take),
        .rearm_i   (rearm),
        .go_o      (go)
    );

    pprx_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .go_i    (go),
        .ready_i (m_ready_i),
        .strb_i  (strb_i),
        .take_o  (take),
        .rearm_o (rearm),
        .ctl_o   (ctl)
    );

    pprx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (take),
        .data_i (data_i),
        .data_o (m_data_o)
    );

    assign busy_o    = ctl.busy;
    assign ack_o     = ctl.ack;
    assign m_valid_o = ctl.offer;

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_o && !ack_o && !m_valid_o)); // R1
    AST_ACK_AFTER_HANDOFF: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> $past(m_valid_o && m_ready_i)); // R5
    AST_ACK_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (rst)
        ack_o |-> busy_o); // R2
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o))); // R4
    AST_IDLE_NO_OFFER: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!m_valid_o && !ack_o)); // R8

endmodule

// File: tb/pport_rx_bench.sv
module pport_rx_bench;
    localparam int DW = 8;
    localparam int NV = 6;
    // {byte, ready delay, strobe hold after ack}
    localparam logic [15:0] VEC [NV] = '{
        16'h6F_0_0, 16'h7A_3_1, 16'h00_1_4, 16'hFF_5_0, 16'h81_0_2, 16'h5C_2_3
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          strb;
    logic [DW-1:0] data;
    logic          busy, ack, mvalid, mready;
    logic [DW-1:0] mdata;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pport_rx #(.DATA_W(DW)) u_pport_rx (
        .clk(clk), .rst(rst), .strb_i(strb), .data_i(data),
        .busy_o(busy), .ack_o(ack), .m_valid_o(mvalid),
        .m_data_o(mdata), .m_ready_i(mready)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic xfer(input logic [DW-1:0] d, input int rdly, input int shold);
        strb = 1'b1;
        data = d;
        @(negedge clk);
        chk(mvalid === 1'b1, "R3 valid", {31'd0, mvalid}, 1);
        chk(mdata === d, "R3 data", {24'd0, mdata}, {24'd0, d});
        chk(busy === 1'b1, "R2 busy after latch", {31'd0, busy}, 1);
        data = ~d;
        for (int i = 0; i < rdly; i++) begin
            @(negedge clk);
            chk(mvalid === 1'b1 && mdata === d, "R4 held",
                {23'd0, mvalid, mdata}, {23'd0, 1'b1, d});
            chk(ack === 1'b0, "R5 no early ack", {31'd0, ack}, 0);
        end
        mready = 1'b1;
        @(negedge clk);
        mready = 1'b0;
        chk(ack === 1'b1 && mvalid === 1'b0, "R5 ack after handoff",
            {30'd0, ack, mvalid}, 32'd2);
        for (int i = 0; i < shold; i++) begin
            @(negedge clk);
            chk(ack === 1'b1 && busy === 1'b1, "R6 ack held",
                {30'd0, ack, busy}, 32'd3);
        end
        strb = 1'b0;
        @(negedge clk);
        chk(ack === 1'b0 && busy === 1'b0, "R6 release",
            {30'd0, ack, busy}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        rst = 1'b1; strb = 1'b1; data = 8'hA5; mready = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && ack === 1'b0 && mvalid === 1'b0, "R1 in reset",
            {29'd0, busy, ack, mvalid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && ack === 1'b0 && mvalid === 1'b0, "R1 after reset",
            {29'd0, busy, ack, mvalid}, 0);
        // R7: strobe stuck high from reset must latch nothing
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(mvalid === 1'b0 && busy === 1'b0, "R7 no latch",
                {30'd0, mvalid, busy}, 0);
        end
        // R8: ready with nothing held is ignored
        mready = 1'b1;
        repeat (2) @(negedge clk);
        chk(ack === 1'b0 && mvalid === 1'b0, "R8 ready ignored",
            {30'd0, ack, mvalid}, 0);
        mready = 1'b0;
        strb = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R2 ready while waiting", {31'd0, busy}, 0);
        xfer(8'h3C, 1, 0);    // first latch after seen-low, R7
        foreach (VEC[k])
            xfer(VEC[k][15:8], int'(VEC[k][7:4]), int'(VEC[k][3:0]));
        finish_run();
    end
endmodule